// File: doc/BRIEF.md
# Indirect Chain Walker

This block follows a chain of indirect words that starts from a segment number and an internal offset produced by the execute cycle. On each level it reads an even-aligned pair of 36-bit words through a simple memory port. It looks at the modifier of the first word to choose one of three steps. An ordinary indirect word stays in the current segment. A direct pair names a new segment in its first word. A based pair picks the new segment from one of eight base registers. The walk stops when a tag asks for no further indirection. The block then strobes the final segment number and offset.

The eight index registers and the eight base registers come in as read-only flattened ports. Memory is addressed directly by the (segment, offset) pair, and no descriptor translation takes place here. A configurable limit on the number of pair reads turns a runaway or circular chain into a fault, so the block cannot hang.

Top module: `iw_chain_walker`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mem_req_o`, `done_o` and `fault_o` are all low.
- R2: Every pair read uses an even offset. An odd offset has bit 0 cleared before the read. The request address stays stable while `mem_req_o` is high and `mem_ack_i` is low.
- R3: Word layout: the address field is bits [35:18] and the modifier/tag is bits [5:0]. A first-word modifier of octal 43 is a direct pair. Its first word's address field becomes the new segment number.
- R4: A first-word modifier of octal 41 is a based pair. The new segment number is the base register selected by the first word's bits [20:18]. Base register k occupies `base_i[18k+17:18k]`.
- R5: Tag encoding: bits [5:4] are the mode, where 00 means stop and 01 means indirect again. Bit [3] enables indexing and bits [2:0] select index register k (`idx_i[18k+17:18k]`). The new offset is the address field plus the selected index, modulo 2^18.
- R6: When the first word is neither a direct nor a based pair, it is an ordinary indirect word. The segment stays unchanged, only that word's address field and tag are used, and the second word is ignored.
- R7: For a direct or based pair, the second word's address field and tag supply the offset, the indexing and the decision to continue. Chains may mix all three kinds of step.
- R8: A walk performs at most MAX_DEPTH pair reads. If the MAX_DEPTH-th read still asks for indirection, the walk ends with a fault. A chain that stops exactly on that read completes normally.
- R9: A mode of 10 or 11 in the governing tag ends the walk with a fault.
- R10: Completion raises `done_o` for one cycle with `res_seg_o`/`res_off_o` holding the result. A fault raises `fault_o` for one cycle. The two strobes never coincide, and each follows an acknowledged read.
- R11: `start_i` is ignored while `busy_o` is high. A start presented in the cycle of a `done_o` or `fault_o` strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk from the given pointer |
| start_seg_i | input | 18 | Segment of the first indirect word |
| start_off_i | input | 18 | Offset of the first indirect word |
| idx_i | input | 144 | Eight 18-bit index registers, flattened |
| base_i | input | 144 | Eight 18-bit base registers, flattened |
| mem_req_o | output | 1 | Pair read request |
| mem_seg_o | output | 18 | Segment of the pair read |
| mem_off_o | output | 18 | Even offset of the pair read |
| mem_ack_i | input | 1 | Read data valid |
| mem_w0_i | input | 36 | Word at the even offset |
| mem_w1_i | input | 36 | Word at the odd offset |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 1 | One-cycle fault strobe |
| res_seg_o | output | 18 | Final segment number |
| res_off_o | output | 18 | Final internal offset |

## Verification
Two functions can meet in the same cycle: the completion strobe of one walk and the acceptance of the next request. The bench waits for `done_o`, then raises `start_i` while that strobe is still high. The scoreboard must then see both results in order. A second start pulse driven in the middle of a running walk must produce no extra result before the bench goes quiet. The monitor reports any unexpected strobe.

// File: rtl/iw_pkg.sv
// Package: shared constants and types for the indirect chain walker.
// Assumes 36-bit words with an 18-bit address field at [35:18] and a 6-bit tag at [5:0].
package iw_pkg;
    localparam int WORD_W  = 36;
    localparam int FLD_W   = 18;
    localparam int TAG_W   = 6;
    localparam int REG_CNT = 8;
    localparam int SEL_W   = $clog2(REG_CNT);
    localparam int FLD_LSB = WORD_W - FLD_W;

    localparam logic [TAG_W-1:0] MOD_DIRECT = 6'o43;
    localparam logic [TAG_W-1:0] MOD_BASED  = 6'o41;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_MORE = 2'b01,
        MODE_BADA = 2'b10,
        MODE_BADB = 2'b11
    } tag_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } walk_state_e;
endpackage

// File: rtl/iw_step_decode.sv
// Module: iw_step_decode
// Combinational decode of one fetched pair into the next (segment, offset) step.
// Assumes the pair words are valid whenever the caller uses the outputs.
module iw_step_decode
    import iw_pkg::*;
(
    input  logic [WORD_W-1:0]        w0_i,
    input  logic [WORD_W-1:0]        w1_i,
    input  logic [FLD_W-1:0]         cur_seg_i,
    input  logic [REG_CNT*FLD_W-1:0] idx_i,
    input  logic [REG_CNT*FLD_W-1:0] base_i,
    output logic [FLD_W-1:0]         nxt_seg_o,
    output logic [FLD_W-1:0]         nxt_off_o,
    output logic                     more_o,
    output logic                     bad_o
);
    logic [FLD_W-1:0] idx_arr  [REG_CNT];
    logic [FLD_W-1:0] base_arr [REG_CNT];

    // Unpack the flattened register files.
    for (genvar k = 0; k < REG_CNT; k++) begin : g_unpack
        assign idx_arr[k]  = idx_i[k*FLD_W +: FLD_W];
        assign base_arr[k] = base_i[k*FLD_W +: FLD_W];
    end

    logic [TAG_W-1:0] mod0;
    logic [TAG_W-1:0] tag;
    logic [FLD_W-1:0] field;
    logic [FLD_W-1:0] addend;
    tag_mode_e        mode;

    assign mod0 = w0_i[TAG_W-1:0];

    // Pick the segment, address field and governing tag from the pair kind.
    always_comb begin
        if (mod0 == MOD_DIRECT) begin
            nxt_seg_o = w0_i[WORD_W-1:FLD_LSB];
            tag       = w1_i[TAG_W-1:0];
            field     = w1_i[WORD_W-1:FLD_LSB];
        end else if (mod0 == MOD_BASED) begin
            nxt_seg_o = base_arr[w0_i[FLD_LSB+SEL_W-1:FLD_LSB]];
            tag       = w1_i[TAG_W-1:0];
            field     = w1_i[WORD_W-1:FLD_LSB];
        end else begin
            nxt_seg_o = cur_seg_i;
            tag       = mod0;
            field     = w0_i[WORD_W-1:FLD_LSB];
        end
    end

    // Apply optional indexing and classify the tag mode.
    always_comb begin
        addend    = tag[SEL_W] ? idx_arr[tag[SEL_W-1:0]] : '0;
        nxt_off_o = field + addend;
        mode      = tag_mode_e'(tag[TAG_W-1:TAG_W-2]);
        more_o    = (mode == MODE_MORE);
        bad_o     = (mode == MODE_BADA) || (mode == MODE_BADB);
    end
endmodule

// File: rtl/iw_depth_ctr.sv
// Module: iw_depth_ctr
// Counts pair reads of the current walk and flags the last one allowed.
// Assumes clr and inc are never high together.
module iw_depth_ctr #(
    parameter int MAX_DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_DEPTH + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_DEPTH - 1);

    logic [CW-1:0] cnt_q;

    // Track reads completed in this walk.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i && !last_o) cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == LAST_VAL);

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_DEPTH));
endmodule

// File: rtl/iw_chain_walker.sv
// Module: iw_chain_walker (top)
// Walks mixed chains of ordinary indirect words and direct/based pairs,
// reading even-aligned word pairs, and strobes the final segment and offset.
// Assumes memory keeps mem_w0_i/mem_w1_i valid in the cycle mem_ack_i is high.
module iw_chain_walker
    import iw_pkg::*;
#(
    parameter int MAX_DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [FLD_W-1:0]         start_seg_i,
    input  logic [FLD_W-1:0]         start_off_i,
    input  logic [REG_CNT*FLD_W-1:0] idx_i,
    input  logic [REG_CNT*FLD_W-1:0] base_i,
    output logic                     mem_req_o,
    output logic [FLD_W-1:0]         mem_seg_o,
    output logic [FLD_W-1:0]         mem_off_o,
    input  logic                     mem_ack_i,
    input  logic [WORD_W-1:0]        mem_w0_i,
    input  logic [WORD_W-1:0]        mem_w1_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     fault_o,
    output logic [FLD_W-1:0]         res_seg_o,
    output logic [FLD_W-1:0]         res_off_o
);
    walk_state_e      state_q;
    logic [FLD_W-1:0] cur_seg_q;
    logic [FLD_W-1:0] cur_off_q;
    logic [FLD_W-1:0] nxt_seg;
    logic [FLD_W-1:0] nxt_off;
    logic             more;
    logic             bad;
    logic             last;
    logic             accept;
    logic             step;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign step   = (state_q == ST_FETCH) && mem_ack_i;

    iw_step_decode u_dec (
        .w0_i      (mem_w0_i),
        .w1_i      (mem_w1_i),
        .cur_seg_i (cur_seg_q),
        .idx_i     (idx_i),
        .base_i    (base_i),
        .nxt_seg_o (nxt_seg),
        .nxt_off_o (nxt_off),
        .more_o    (more),
        .bad_o     (bad)
    );

    iw_depth_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .inc_i  (step),
        .last_o (last)
    );

    // Sequence the walk: accept, fetch pairs, and strobe the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_seg_q <= '0;
            cur_off_q <= '0;
            done_o    <= 1'b0;
            fault_o   <= 1'b0;
            res_seg_o <= '0;
            res_off_o <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            if (accept) begin
                cur_seg_q <= start_seg_i;
                cur_off_q <= {start_off_i[FLD_W-1:1], 1'b0};
                state_q   <= ST_FETCH;
            end else if (step) begin
                if (bad || (more && last)) begin
                    fault_o <= 1'b1;
                    state_q <= ST_IDLE;
                end else if (more) begin
                    cur_seg_q <= nxt_seg;
                    cur_off_q <= {nxt_off[FLD_W-1:1], 1'b0};
                end else begin
                    done_o    <= 1'b1;
                    res_seg_o <= nxt_seg;
                    res_off_o <= nxt_off;
                    state_q   <= ST_IDLE;
                end
            end
        end
    end

    assign mem_req_o = (state_q == ST_FETCH);
    assign mem_seg_o = cur_seg_q;
    assign mem_off_o = cur_off_q;
    assign busy_o    = (state_q != ST_IDLE);

    a_r2_even_offset: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !mem_off_o[0]);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_seg_o) && $stable(mem_off_o)));
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));
    a_r10_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |-> $past(mem_ack_i && mem_req_o));
    a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !mem_ack_i) |=> (busy_o && $stable(mem_seg_o) && $stable(mem_off_o)));
    a_r11_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && mem_req_o));
endmodule

// File: tb/tb_iw_chain_walker.sv
module tb_iw_chain_walker;
    localparam int MAXD = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [17:0] start_seg_i = '0, start_off_i = '0;
    logic [143:0] idx_i, base_i;
    logic mem_req_o, mem_ack_i = 1'b0;
    logic [17:0] mem_seg_o, mem_off_o;
    logic [35:0] mem_w0_i = '0, mem_w1_i = '0;
    logic busy_o, done_o, fault_o;
    logic [17:0] res_seg_o, res_off_o;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    typedef struct { bit flt; logic [17:0] seg; logic [17:0] off; string req; } exp_t;
    exp_t q[$];
    logic [35:0] mem [logic [35:0]];

    always #5 clk = ~clk;

    iw_chain_walker #(.MAX_DEPTH(MAXD)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_seg_i(start_seg_i),
        .start_off_i(start_off_i), .idx_i(idx_i), .base_i(base_i),
        .mem_req_o(mem_req_o), .mem_seg_o(mem_seg_o), .mem_off_o(mem_off_o),
        .mem_ack_i(mem_ack_i), .mem_w0_i(mem_w0_i), .mem_w1_i(mem_w1_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
        .res_seg_o(res_seg_o), .res_off_o(res_off_o));

    // Index register k = 0x10*k+1, base register k = 0x300+k.
    initial begin
        for (int k = 0; k < 8; k++) begin
            idx_i[k*18 +: 18]  = 18'(16*k + 1);
            base_i[k*18 +: 18] = 18'(12'h300 + k);
        end
    end

    function automatic logic [35:0] mkw(logic [17:0] a, logic [5:0] t);
        return {a, 12'h000, t};
    endfunction

    function automatic logic [35:0] rd(logic [17:0] s, logic [17:0] o);
        logic [35:0] key = {s, o};
        return mem.exists(key) ? mem[key] : 36'h0;
    endfunction

    task automatic put(logic [17:0] s, logic [17:0] o, logic [35:0] w);
        mem[{s, o}] = w;
    endtask

    task automatic check(bit ok, string req, string msg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Reference walk built from R3-R9.
    task automatic ref_walk(input logic [17:0] s0, input logic [17:0] o0, output exp_t e);
        logic [17:0] s = s0, o = o0, ns, ad, no;
        logic [35:0] w0, w1;
        logic [5:0] t;
        e.flt = 1; e.seg = 0; e.off = 0;
        for (int n = 1; n <= MAXD; n++) begin
            w0 = rd(s, {o[17:1], 1'b0});
            w1 = rd(s, {o[17:1], 1'b1});
            if (w0[5:0] == 6'o43) begin ns = w0[35:18]; t = w1[5:0]; ad = w1[35:18]; end
            else if (w0[5:0] == 6'o41) begin ns = base_i[w0[20:18]*18 +: 18]; t = w1[5:0]; ad = w1[35:18]; end
            else begin ns = s; t = w0[5:0]; ad = w0[35:18]; end
            no = ad + (t[3] ? idx_i[t[2:0]*18 +: 18] : 18'h0);
            if (t[5:4] == 2'b00) begin e.flt = 0; e.seg = ns; e.off = no; return; end
            else if (t[5:4] == 2'b01) begin s = ns; o = no; end
            else return;
        end
    endtask

    task automatic send(logic [17:0] s, logic [17:0] o, string req);
        exp_t e;
        ref_walk(s, o, e);
        e.req = req;
        q.push_back(e);
        start_seg_i = s; start_off_i = o; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Memory responder: one-cycle acks, checks even alignment (R2).
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack_i) mem_ack_i = 1'b0;
            else if (mem_req_o) begin
                check(mem_off_o[0] == 1'b0, "R2", $sformatf("odd read offset act=%h exp=even", mem_off_o));
                mem_w0_i  = rd(mem_seg_o, mem_off_o);
                mem_w1_i  = rd(mem_seg_o, mem_off_o | 18'h1);
                mem_ack_i = 1'b1;
            end
        end
    end

    // Monitor: pop and compare every strobe (R10).
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && (done_o || fault_o)) begin
                check(!(done_o && fault_o), "R10", "done and fault together act=11 exp=one");
                if (q.size() == 0) begin
                    check(0, "R11", $sformatf("unexpected strobe act=done%0b/fault%0b exp=none", done_o, fault_o));
                end else begin
                    e = q.pop_front();
                    if (e.flt)
                        check(fault_o, e.req, $sformatf("act=done exp=fault (seg=%h off=%h)", res_seg_o, res_off_o));
                    else
                        check(done_o && res_seg_o == e.seg && res_off_o == e.off, e.req,
                              $sformatf("act=%0b %h:%h exp=1 %h:%h", done_o, res_seg_o, res_off_o, e.seg, e.off));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R6 plain stop word.
        put(5, 18'h10, mkw(18'h123, 6'o00));
        // R5 indexed stop word (idx3 = 0x31) and wraparound with idx1 (0x11).
        put(5, 18'h20, mkw(18'h100, 6'b00_1_011));
        put(5, 18'h22, mkw(18'h3FFFF, 6'b00_1_001));
        // R3 direct pair.
        put(7, 18'h40, mkw(18'h77, 6'o43)); put(7, 18'h41, mkw(18'h200, 6'o00));
        // R4 based pair via base5 = 0x305.
        put(7, 18'h50, mkw(18'h5, 6'o41)); put(7, 18'h51, mkw(18'h222, 6'o00));
        // R7 mixed chain: RI -> direct (idx2) -> based -> RI indexed stop.
        put(1, 18'h20, mkw(18'h30, 6'o20));
        put(1, 18'h30, mkw(18'h44, 6'o43)); put(1, 18'h31, mkw(18'h50, 6'b01_1_010));
        put(18'h44, 18'h70, mkw(18'h3, 6'o41)); put(18'h44, 18'h71, mkw(18'h80, 6'o20));
        put(18'h303, 18'h80, mkw(18'h91, 6'b00_1_001));
        // R8 chain of exactly MAXD reads, and a circular chain.
        for (int k = 0; k < MAXD; k++)
            put(2, 18'(18'h1000 + 2*k), (k == MAXD-1) ? mkw(18'h5AB, 6'o00)
                                                       : mkw(18'(18'h1000 + 2*(k+1)), 6'o20));
        put(9, 18'h40, mkw(18'h40, 6'o20));
        // R9 bad modes.
        put(6, 18'h0, mkw(18'h10, 6'o40));
        put(6, 18'h8, mkw(18'h12, 6'o43)); put(6, 18'h9, mkw(18'h0, 6'o60));

        repeat (3) @(negedge clk);
        // R1 reset state.
        check(!busy_o && !mem_req_o && !done_o && !fault_o, "R1",
              $sformatf("act=%0b%0b%0b%0b exp=0000", busy_o, mem_req_o, done_o, fault_o));
        rst_n = 1'b1;
        @(negedge clk);

        send(5, 18'h10, "R6");        drain();
        send(5, 18'h20, "R5");        drain();
        send(5, 18'h22, "R5");        drain();
        send(5, 18'h11, "R2");        drain();   // odd start reads pair at 0x10
        send(7, 18'h40, "R3");        drain();
        send(7, 18'h50, "R4");        drain();
        send(1, 18'h20, "R7");        drain();
        send(2, 18'h1000, "R8");      drain();
        send(9, 18'h40, "R8");        drain();
        send(6, 18'h0, "R9");         drain();
        send(6, 18'h8, "R9");         drain();

        // R11: start during busy is ignored; start in the done cycle is accepted.
        send(1, 18'h20, "R11");
        @(negedge clk);
        start_seg_i = 5; start_off_i = 18'h20; start_i = 1'b1;   // not expected
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        send(7, 18'h40, "R11");
        drain();
        repeat (20) @(negedge clk);
        check(q.size() == 0 && !busy_o, "R11",
              $sformatf("act=q%0d busy%0b exp=q0 busy0", q.size(), busy_o));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule